// File: doc/BRIEF.md
# Banked Work-RAM Address Decoder

This block turns a 16-bit processor address into chip selects and physical addresses for a small handheld-style memory map. The upper quarter of the address space holds 8 KiB of work-RAM windows. The lower 4 KiB window always reaches bank 0. The upper 4 KiB window reaches a bank chosen by a 3-bit select register. Both windows are mirrored once more directly above, up to the start of the register area. A small high-RAM area near the top of the map gets its own select.

At reset, a boot-ROM overlay covers the first 256 bytes of the map. In colour mode it also covers a second window at 0x0200–0x08FF. A single write to a retire register turns the overlay off for good, until the next reset.

All outputs are combinational from the address, the write strobe and the two pieces of registered state: the bank select and the overlay flag. The block holds no RAM arrays, and it does not decode cartridge space or video memory.

Top module: `banked_wram_decoder`

## Requirements
- R1: Addresses 0xC000–0xCFFF assert `wram_sel` with `wram_addr` = {3'd0, addr[11:0]} (bank 0).
- R2: Addresses 0xD000–0xDFFF assert `wram_sel` with `wram_addr` = {bank, addr[11:0]}, where bank is the stored 3-bit select and a stored value of 0 is used as 1.
- R3: Addresses 0xE000–0xFDFF mirror the two windows below: bit 12 of the address picks bank 0 or the switchable bank exactly as in R1/R2. At 0xFE00 and above, `wram_sel` is low.
- R4: The bank select register sits at 0xFF70 and keeps only data bits 2:0. A non-write access to it asserts `bank_rd_sel` and drives `bank_rdata` = {5'b11111, bank}.
- R5: While `color_en` is low, writes to 0xFF70 leave the stored value unchanged, both windows with address bit 12 set use bank 1, and `bank_rdata` reads 0xFF.
- R6: After reset, the bank select holds 1 (reads back 0xF9 in colour mode) and the boot overlay is active.
- R7: While the overlay is active, non-write accesses to 0x0000–0x00FF assert `boot_sel` with `boot_addr` = addr[11:0]. In colour mode the same holds for 0x0200–0x08FF. 0x0100–0x01FF and 0x0900 and above are never in the overlay.
- R8: A write to 0xFF50 with data bit 0 set retires the overlay until reset. A write there with bit 0 clear has no effect. A write into an overlay window never asserts `boot_sel`.
- R9: Addresses 0xFF80–0xFFFE assert `hram_sel` with `hram_addr` = addr[6:0]. Address 0xFFFF does not.
- R10: At most one of `wram_sel`, `boot_sel`, `hram_sel` and `bank_rd_sel` is high. `wram_we` and `hram_we` equal their select ANDed with `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| color_en | input | 1 | Colour mode enable |
| addr | input | 16 | Processor address |
| wr_en | input | 1 | Write strobe for the current access |
| wdata | input | 8 | Write data |
| wram_sel | output | 1 | Work-RAM chip select |
| wram_we | output | 1 | Work-RAM write enable |
| wram_addr | output | 15 | Physical work-RAM address (bank, offset) |
| boot_sel | output | 1 | Boot-ROM read select |
| boot_addr | output | 12 | Boot-ROM byte address |
| hram_sel | output | 1 | High-RAM chip select |
| hram_we | output | 1 | High-RAM write enable |
| hram_addr | output | 7 | High-RAM byte address |
| bank_rd_sel | output | 1 | Read of the bank select register |
| bank_rdata | output | 8 | Bank select register read value |

## Verification
The switchable window is exercised by writing every select value 0 through 7, plus a value with upper bits set. This separates correct zero-to-one promotion and bit masking from a plain pass-through. Mirror addresses are probed on both sides of bit 12 and at the 0xFDFF/0xFE00 edge, which distinguishes a correct mirror from one that leaks into register space. Toggling colour mode around a bank write shows whether the register is really frozen, not just masked on readback. The overlay is probed at both edges of each window, in both modes, and before and after retire writes with bit 0 clear and with bit 0 set.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int BANK_W  = 3;
    localparam int OFF_W   = 12;
    localparam int HRAM_W  = 7;
    localparam int BOOT_W  = 12;
    localparam int PHYS_W  = BANK_W + OFF_W;

    localparam logic [ADDR_W-1:0] BANK_REG_ADDR  = 16'hFF70;
    localparam logic [ADDR_W-1:0] BOOT_OFF_ADDR  = 16'hFF50;
    localparam logic [ADDR_W-1:0] REG_AREA_BASE  = 16'hFE00;
    localparam logic [ADDR_W-1:0] HRAM_BASE      = 16'hFF80;
    localparam logic [ADDR_W-1:0] HRAM_LAST      = 16'hFFFE;
    localparam logic [ADDR_W-1:0] WRAM_BASE      = 16'hC000;
    localparam logic [ADDR_W-1:0] BOOT_LO_LAST   = 16'h00FF;
    localparam logic [ADDR_W-1:0] BOOT_HI_FIRST  = 16'h0200;
    localparam logic [ADDR_W-1:0] BOOT_HI_LAST   = 16'h08FF;
    localparam logic [BANK_W-1:0] BANK_RESET     = 3'd1;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_WRAM,
        RGN_BOOT,
        RGN_HRAM,
        RGN_BANKREG
    } region_e;

    typedef struct packed {
        region_e             rgn;
        logic [PHYS_W-1:0]   wram_addr;
        logic [BOOT_W-1:0]   boot_addr;
        logic [HRAM_W-1:0]   hram_addr;
    } decode_t;

    function automatic logic [BANK_W-1:0] effective_bank(
        input logic [BANK_W-1:0] stored,
        input logic              colour
    );
        if (!colour)
            return BANK_RESET;
        return (stored == '0) ? BANK_RESET : stored;
    endfunction

    function automatic logic in_boot_window(
        input logic [ADDR_W-1:0] a,
        input logic              colour
    );
        logic lo_hit, hi_hit;
        lo_hit = (a <= BOOT_LO_LAST);
        hi_hit = colour && (a >= BOOT_HI_FIRST) && (a <= BOOT_HI_LAST);
        return lo_hit || hi_hit;
    endfunction

endpackage

// File: rtl/wram_bank_reg.sv
module wram_bank_reg
    import wram_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              color_en,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic [BANK_W-1:0] bank_eff,
    output logic [DATA_W-1:0] rd_value
);
    localparam int PAD_W = DATA_W - BANK_W;

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= BANK_RESET;
        else if (wr_hit && color_en)
            bank_q <= wdata[BANK_W-1:0];
    end

    always_comb begin
        bank_eff = effective_bank(bank_q, color_en);
        rd_value = color_en ? {{PAD_W{1'b1}}, bank_q} : {DATA_W{1'b1}};
    end
endmodule

// File: rtl/boot_overlay_latch.sv
module boot_overlay_latch
    import wram_map_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic retire_hit,
    input  logic retire_bit,
    output logic overlay_on
);
    always_ff @(posedge clk) begin
        if (rst)
            overlay_on <= 1'b1;
        else if (retire_hit && retire_bit)
            overlay_on <= 1'b0;
    end
endmodule

// File: rtl/map_region_decode.sv
module map_region_decode
    import wram_map_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              color_en,
    input  logic              overlay_on,
    input  logic [BANK_W-1:0] bank_eff,
    output decode_t           dec
);
    always_comb begin
        dec           = '0;
        dec.rgn       = RGN_NONE;
        dec.boot_addr = addr[BOOT_W-1:0];
        dec.hram_addr = addr[HRAM_W-1:0];
        dec.wram_addr = {(addr[OFF_W] ? bank_eff : {BANK_W{1'b0}}), addr[OFF_W-1:0]};
        if (addr >= REG_AREA_BASE) begin
            if (addr >= HRAM_BASE && addr <= HRAM_LAST)
                dec.rgn = RGN_HRAM;
            else if (addr == BANK_REG_ADDR && !wr_en)
                dec.rgn = RGN_BANKREG;
        end else if (addr >= WRAM_BASE) begin
            dec.rgn = RGN_WRAM;
        end else if (overlay_on && !wr_en && in_boot_window(addr, color_en)) begin
            dec.rgn = RGN_BOOT;
        end
    end
endmodule

// File: rtl/banked_wram_decoder.sv
module banked_wram_decoder
    import wram_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              color_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              wram_sel,
    output logic              wram_we,
    output logic [PHYS_W-1:0] wram_addr,
    output logic              boot_sel,
    output logic [BOOT_W-1:0] boot_addr,
    output logic              hram_sel,
    output logic              hram_we,
    output logic [HRAM_W-1:0] hram_addr,
    output logic              bank_rd_sel,
    output logic [DATA_W-1:0] bank_rdata
);
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] bank_eff;
    logic              overlay_on;
    decode_t           dec;

    wram_bank_reg u_bank (
        .clk      (clk),
        .rst      (rst),
        .color_en (color_en),
        .wr_hit   (wr_en && addr == BANK_REG_ADDR),
        .wdata    (wdata),
        .bank_q   (bank_q),
        .bank_eff (bank_eff),
        .rd_value (bank_rdata)
    );

    boot_overlay_latch u_boot (
        .clk        (clk),
        .rst        (rst),
        .retire_hit (wr_en && addr == BOOT_OFF_ADDR),
        .retire_bit (wdata[0]),
        .overlay_on (overlay_on)
    );

    map_region_decode u_dec (
        .addr       (addr),
        .wr_en      (wr_en),
        .color_en   (color_en),
        .overlay_on (overlay_on),
        .bank_eff   (bank_eff),
        .dec        (dec)
    );

    always_comb begin
        wram_sel    = (dec.rgn == RGN_WRAM);
        boot_sel    = (dec.rgn == RGN_BOOT);
        hram_sel    = (dec.rgn == RGN_HRAM);
        bank_rd_sel = (dec.rgn == RGN_BANKREG);
        wram_we     = wram_sel && wr_en;
        hram_we     = hram_sel && wr_en;
        wram_addr   = dec.wram_addr;
        boot_addr   = dec.boot_addr;
        hram_addr   = dec.hram_addr;
    end
endmodule

// File: rtl/banked_wram_decoder_chk.sv
module banked_wram_decoder_chk
    import wram_map_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              color_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              wram_sel,
    input logic [PHYS_W-1:0] wram_addr,
    input logic              boot_sel,
    input logic              hram_sel,
    input logic              bank_rd_sel,
    input logic [DATA_W-1:0] bank_rdata,
    input logic [BANK_W-1:0] bank_q,
    input logic              overlay_on
);
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        $countones({wram_sel, boot_sel, hram_sel, bank_rd_sel}) <= 1); // R10
    AST_LOW_WINDOW_BANK0: assert property (@(posedge clk) disable iff (rst)
        (wram_sel && !addr[OFF_W]) |-> wram_addr[PHYS_W-1:OFF_W] == '0); // R1
    AST_HIGH_WINDOW_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (wram_sel && addr[OFF_W]) |-> wram_addr[PHYS_W-1:OFF_W] != '0); // R2
    AST_NO_WRAM_IN_REGS: assert property (@(posedge clk) disable iff (rst)
        (addr >= REG_AREA_BASE) |-> !wram_sel); // R3
    AST_BANKREG_PAD: assert property (@(posedge clk) disable iff (rst)
        bank_rd_sel |-> bank_rdata[DATA_W-1:BANK_W] == '1); // R4
    AST_MONO_BANK_ONE: assert property (@(posedge clk) disable iff (rst)
        (!color_en && wram_sel && addr[OFF_W]) |-> wram_addr[PHYS_W-1:OFF_W] == BANK_RESET); // R5
    AST_MONO_BANK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !color_en |=> $stable(bank_q)); // R5
    AST_OVERLAY_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
        !overlay_on |=> !overlay_on); // R8
    AST_NO_BOOT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !boot_sel); // R8
    AST_BOOT_NEEDS_OVERLAY: assert property (@(posedge clk) disable iff (rst)
        boot_sel |-> overlay_on); // R7
    AST_HRAM_RANGE: assert property (@(posedge clk) disable iff (rst)
        hram_sel |-> (addr >= HRAM_BASE && addr != 16'hFFFF)); // R9
endmodule

bind banked_wram_decoder banked_wram_decoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .color_en    (color_en),
    .addr        (addr),
    .wr_en       (wr_en),
    .wram_sel    (wram_sel),
    .wram_addr   (wram_addr),
    .boot_sel    (boot_sel),
    .hram_sel    (hram_sel),
    .bank_rd_sel (bank_rd_sel),
    .bank_rdata  (bank_rdata),
    .bank_q      (bank_q),
    .overlay_on  (overlay_on)
);

// File: tb/banked_wram_decoder_tb_top.sv
module banked_wram_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        color_en = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic        wram_sel, wram_we, boot_sel, hram_sel, hram_we, bank_rd_sel;
    logic [14:0] wram_addr;
    logic [11:0] boot_addr;
    logic [6:0]  hram_addr;
    logic [7:0]  bank_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    banked_wram_decoder dut_i (
        .clk(clk), .rst(rst), .color_en(color_en), .addr(addr),
        .wr_en(wr_en), .wdata(wdata),
        .wram_sel(wram_sel), .wram_we(wram_we), .wram_addr(wram_addr),
        .boot_sel(boot_sel), .boot_addr(boot_addr),
        .hram_sel(hram_sel), .hram_we(hram_we), .hram_addr(hram_addr),
        .bank_rd_sel(bank_rd_sel), .bank_rdata(bank_rdata)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic probe(input logic [15:0] a);
        @(negedge clk);
        addr  = a;
        wr_en = 1'b0;
        #1;
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Expected physical address: bank 0 when bit 12 clear, else select (0 -> 1, mono -> 1)
    function automatic int exp_wram(input logic [15:0] a, input int sel, input bit colour);
        int b;
        b = colour ? ((sel == 0) ? 1 : sel) : 1;
        if (!a[12]) b = 0;
        return (b << 12) | a[11:0];
    endfunction

    task automatic t_reset;
        probe(16'hFF70);
        chk("R6", "bank readback after reset", bank_rdata, 8'hF9);
        chk("R4", "bank_rd_sel", bank_rd_sel, 1);
        probe(16'h0000);
        chk("R6", "overlay active after reset", boot_sel, 1);
    endtask

    task automatic t_fixed_bank;
        probe(16'hC123);
        chk("R1", "sel C123", wram_sel, 1);
        chk("R1", "addr C123", wram_addr, 16'h0123);
        probe(16'hCFFF);
        chk("R1", "addr CFFF", wram_addr, 16'h0FFF);
    endtask

    task automatic t_switch_bank;
        for (int b = 0; b < 8; b++) begin
            write_reg(16'hFF70, 8'(b));
            probe(16'hD456);
            chk("R2", $sformatf("bank %0d D456", b), wram_addr, exp_wram(16'hD456, b, 1'b1));
        end
        write_reg(16'hFF70, 8'hFD);
        probe(16'hFF70);
        chk("R4", "masked readback", bank_rdata, 8'hFD);
        probe(16'hDFFF);
        chk("R2", "addr DFFF bank 5", wram_addr, 16'h5FFF);
    endtask

    task automatic t_mirror;
        write_reg(16'hFF70, 8'h03);
        probe(16'hE010);
        chk("R3", "mirror E010", wram_addr, exp_wram(16'hE010, 3, 1'b1));
        probe(16'hF010);
        chk("R3", "mirror F010", wram_addr, exp_wram(16'hF010, 3, 1'b1));
        probe(16'hFDFF);
        chk("R3", "mirror FDFF sel", wram_sel, 1);
        chk("R3", "mirror FDFF", wram_addr, 16'h3DFF);
        probe(16'hFE00);
        chk("R3", "FE00 not wram", wram_sel, 0);
    endtask

    task automatic t_mono;
        write_reg(16'hFF70, 8'h06);
        @(negedge clk);
        color_en = 1'b0;
        probe(16'hD000);
        chk("R5", "mono D000", wram_addr, 16'h1000);
        probe(16'hF234);
        chk("R5", "mono F234", wram_addr, 16'h1234);
        probe(16'hFF70);
        chk("R5", "mono readback", bank_rdata, 8'hFF);
        write_reg(16'hFF70, 8'h02);
        @(negedge clk);
        color_en = 1'b1;
        probe(16'hFF70);
        chk("R5", "mono write ignored", bank_rdata, 8'hFE);
    endtask

    task automatic t_boot;
        probe(16'h00FF);
        chk("R7", "00FF sel", boot_sel, 1);
        chk("R7", "00FF addr", boot_addr, 12'h0FF);
        probe(16'h0100);
        chk("R7", "0100 gap", boot_sel, 0);
        probe(16'h0200);
        chk("R7", "0200 sel", boot_sel, 1);
        chk("R7", "0200 addr", boot_addr, 12'h200);
        probe(16'h08FF);
        chk("R7", "08FF sel", boot_sel, 1);
        probe(16'h0900);
        chk("R7", "0900 out", boot_sel, 0);
        @(negedge clk);
        color_en = 1'b0;
        probe(16'h0300);
        chk("R7", "mono 0300", boot_sel, 0);
        probe(16'h0050);
        chk("R7", "mono 0050", boot_sel, 1);
        @(negedge clk);
        color_en = 1'b1;
        addr  = 16'h0010;
        wr_en = 1'b1;
        #1;
        chk("R8", "write into overlay", boot_sel, 0);
        @(negedge clk);
        wr_en = 1'b0;
        write_reg(16'hFF50, 8'hFE);
        probe(16'h0000);
        chk("R8", "bit0 clear keeps overlay", boot_sel, 1);
        write_reg(16'hFF50, 8'h01);
        probe(16'h0000);
        chk("R8", "retired low window", boot_sel, 0);
        write_reg(16'hFF50, 8'h00);
        probe(16'h0200);
        chk("R8", "retired high window", boot_sel, 0);
    endtask

    task automatic t_hram;
        probe(16'hFF80);
        chk("R9", "FF80 sel", hram_sel, 1);
        chk("R9", "FF80 addr", hram_addr, 0);
        probe(16'hFFFE);
        chk("R9", "FFFE addr", hram_addr, 7'h7E);
        probe(16'hFFFF);
        chk("R9", "FFFF not hram", hram_sel, 0);
        probe(16'hFF7F);
        chk("R9", "FF7F not hram", hram_sel, 0);
        @(negedge clk);
        addr  = 16'hFF85;
        wr_en = 1'b1;
        #1;
        chk("R10", "hram_we", hram_we, 1);
        chk("R10", "no wram on hram write", wram_sel, 0);
        addr = 16'hD000;
        #1;
        chk("R10", "wram_we", wram_we, 1);
        chk("R10", "no hram on wram write", hram_sel, 0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R10", "wram_we off on read", wram_we, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fixed_bank();
        t_switch_bank();
        t_mirror();
        t_mono();
        t_boot();
        t_hram();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule